// File: doc/BRIEF.md
# Audio Master Clock Ratio Generator

This block turns a master clock into the timing a serial audio port needs when it drives the clocks itself. It sends out a bit clock, a frame (left/right) clock and a one-cycle strobe that marks the start of each frame for a serialiser. The frame length counts in core clocks. The core clock is the master clock, or the master clock halved. Two control bits pick one of four frame lengths. One family serves 12 MHz-style master clocks at 250 or 272 core clocks per frame. The other serves the usual 256 or 384 ratios.

Every counter runs on the master clock. When halving is selected, a core-tick enable moves the frame counter forward on every second master cycle. A configuration that changes mid-frame is held back until the current frame ends, so the clocks never put out a shortened pulse. With the master enable low, the block is in slave operation: every output is held low and the frame counter sits at its origin.

Top module: `audio_clk_gen`

## Requirements
- R1: With `usb_mode_i`=0 and `base_rate_i`=0, one frame lasts 256 core clocks.
- R2: With `usb_mode_i`=0 and `base_rate_i`=1, one frame lasts 384 core clocks.
- R3: With `usb_mode_i`=1 and `base_rate_i`=0, one frame lasts 250 core clocks.
- R4: With `usb_mode_i`=1 and `base_rate_i`=1, one frame lasts 272 core clocks.
- R5: With `mclk_div2_i`=1, each core clock lasts two master cycles, so every frame is twice as long in master cycles. The frame counter never advances on two master cycles in a row.
- R6: Let p be the core-clock position inside the frame, counted from 0. `lrclk_o` is high while p < ratio/2 (128, 192, 125 or 136) and low for the rest of the frame. It rises only at p = 0.
- R7: In the normal family, `bclk_o` is bit 1 of p, so it toggles every two core clocks. In the USB family, `bclk_o` is bit 0 of p, so it is the core clock halved. Both start low at p = 0.
- R8: `frame_start_o` is high for exactly one master cycle per frame: the cycle at p = 0 in which the core tick fires. That is the first master cycle of the frame when the core clock is not halved, and the second when it is. `lrclk_o` is high and `bclk_o` low during that cycle.
- R9: The mode, base-rate and divide inputs are sampled only when the block starts running and at the end of each frame. A change in the middle of a frame leaves that frame's length and clocks as they were.
- R10: After a master cycle with `master_en_i`=0, all three outputs are low and the frame position returns to 0. At the first clock edge with the enable high again, a new frame starts at p = 0.
- R11: During reset all outputs are low. At the first clock edge after reset is released with `master_en_i`=1, the block starts at p = 0, so `lrclk_o` is high in the master cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_en_i | input | 1 | 1 = generate clocks (master), 0 = hold outputs low (slave) |
| usb_mode_i | input | 1 | 1 = 250/272 ratio family, 0 = 256/384 family |
| base_rate_i | input | 1 | Selects the lower (0) or higher (1) ratio within the family |
| mclk_div2_i | input | 1 | 1 = core clock is the master clock halved |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock, high for the first half of the frame |
| frame_start_o | output | 1 | One-master-cycle strobe at the start of each frame |

## Verification
All three outputs are decoded combinationally from registers that the rising edge of the master clock updates. Each result therefore belongs to the master cycle that follows an edge. The bench samples at the falling edge and gives each sample an index t, counted from the first running edge. The expected position is t (or t/2 when halved) modulo the ratio. Configuration changes and enable changes are applied just after a falling-edge sample, so the next rising edge is the first one that can act on them. For a change in the middle of a frame, the bench expects the old ratio until exactly one frame of the old length has elapsed.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  typedef struct packed {
    logic usb;
    logic base;
    logic div2;
  } clk_cfg_t;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/aclk_core_tick.sv
module aclk_core_tick (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic div2_i,
  input  logic wrap_i,
  output logic tick_o
);

  logic phase_q;

  // phase restarts at each frame so halving keeps a fixed origin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          phase_q <= 1'b0;
    else if (!run_i || wrap_i || !div2_i) phase_q <= 1'b0;
    else                                  phase_q <= ~phase_q;
  end

  assign tick_o = !div2_i || phase_q;

  assert_tick_halved_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && div2_i && tick_o) |=> (!tick_o || !div2_i || !run_i));

endmodule

// File: rtl/aclk_frame_cnt.sv
module aclk_frame_cnt
  import aclk_pkg::*;
#(
  parameter int unsigned R_USB_LO = 250,
  parameter int unsigned R_USB_HI = 272,
  parameter int unsigned R_NRM_LO = 256,
  parameter int unsigned R_NRM_HI = 384,
  parameter int unsigned CNT_W    = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_en_i,
  input  clk_cfg_t         cfg_in_i,
  input  logic             tick_i,
  output logic             run_o,
  output clk_cfg_t         cfg_o,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] half_o,
  output logic             wrap_o
);

  logic             run_q;
  clk_cfg_t         cfg_q;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] ratio;

  always_comb begin
    unique case ({cfg_q.usb, cfg_q.base})
      2'b00:   ratio = CNT_W'(R_NRM_LO);
      2'b01:   ratio = CNT_W'(R_NRM_HI);
      2'b10:   ratio = CNT_W'(R_USB_LO);
      default: ratio = CNT_W'(R_USB_HI);
    endcase
  end

  assign wrap_o = run_q && tick_i && (pos_q == ratio - 1'b1);
  assign half_o = ratio >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pos_q <= '0;
      cfg_q <= '0;
    end else if (!master_en_i || !run_q) begin
      run_q <= master_en_i;
      pos_q <= '0;
      cfg_q <= cfg_in_i;
    end else if (wrap_o) begin
      pos_q <= '0;
      cfg_q <= cfg_in_i;  // new settings only at the frame boundary
    end else if (tick_i) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign run_o = run_q;
  assign cfg_o = cfg_q;
  assign pos_o = pos_q;

  assert_pos_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (pos_q < ratio));

  assert_cfg_frame_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && !$past(wrap_o)) |-> (cfg_q == $past(cfg_q)));

endmodule

// File: rtl/aclk_out_gen.sv
module aclk_out_gen #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             run_i,
  input  logic             usb_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] pos_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             frame_start_o
);

  assign lrclk_o       = run_i && (pos_i < half_i);
  assign bclk_o        = run_i && (usb_i ? pos_i[0] : pos_i[1]);
  assign frame_start_o = run_i && tick_i && (pos_i == '0);

endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import aclk_pkg::*;
#(
  parameter int unsigned R_USB_LO = 250,
  parameter int unsigned R_USB_HI = 272,
  parameter int unsigned R_NRM_LO = 256,
  parameter int unsigned R_NRM_HI = 384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_en_i,
  input  logic usb_mode_i,
  input  logic base_rate_i,
  input  logic mclk_div2_i,
  output logic bclk_o,
  output logic lrclk_o,
  output logic frame_start_o
);

  localparam int unsigned R_MAX = max4(R_USB_LO, R_USB_HI, R_NRM_LO, R_NRM_HI);
  localparam int unsigned CNT_W = $clog2(R_MAX);

  clk_cfg_t         cfg_in, cfg;
  logic             run, tick, wrap;
  logic [CNT_W-1:0] pos, half;

  assign cfg_in = '{usb: usb_mode_i, base: base_rate_i, div2: mclk_div2_i};

  aclk_core_tick u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div2_i (cfg.div2),
    .wrap_i (wrap),
    .tick_o (tick)
  );

  aclk_frame_cnt #(
    .R_USB_LO (R_USB_LO),
    .R_USB_HI (R_USB_HI),
    .R_NRM_LO (R_NRM_LO),
    .R_NRM_HI (R_NRM_HI),
    .CNT_W    (CNT_W)
  ) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .master_en_i (master_en_i),
    .cfg_in_i    (cfg_in),
    .tick_i      (tick),
    .run_o       (run),
    .cfg_o       (cfg),
    .pos_o       (pos),
    .half_o      (half),
    .wrap_o      (wrap)
  );

  aclk_out_gen #(.CNT_W(CNT_W)) u_out (
    .run_i         (run),
    .usb_i         (cfg.usb),
    .tick_i        (tick),
    .pos_i         (pos),
    .half_i        (half),
    .bclk_o        (bclk_o),
    .lrclk_o       (lrclk_o),
    .frame_start_o (frame_start_o)
  );

  assert_slave_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_en_i |=> (!bclk_o && !lrclk_o && !frame_start_o));

  assert_start_in_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (lrclk_o && !bclk_o));

  assert_lr_rise_origin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lrclk_o) |-> (pos == '0));

endmodule

// File: tb/audio_clk_gen_test.sv
`timescale 1ns/1ps
module audio_clk_gen_test;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master_en, usb_mode, base_rate, div2;
  logic bclk, lrclk, fstart;
  int   n_checks = 0;
  int   n_errors = 0;

  always #5 clk = ~clk;

  audio_clk_gen uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .master_en_i   (master_en),
    .usb_mode_i    (usb_mode),
    .base_rate_i   (base_rate),
    .mclk_div2_i   (div2),
    .bclk_o        (bclk),
    .lrclk_o       (lrclk),
    .frame_start_o (fstart)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected outputs at master cycle t of a steady configuration
  task automatic expect_at(input int t, input int r, input bit usb, input bit dv,
                           output bit e_lr, output bit e_bc, output bit e_fs);
    int core, pos;
    core = dv ? t / 2 : t;
    pos  = core % r;
    e_lr = pos < r / 2;
    e_bc = usb ? pos[0] : pos[1];
    e_fs = (pos == 0) && (!dv || (t % 2 == 1));
  endtask

  // R11: outputs low in reset, block starts on the first edge after release
  task automatic do_reset(input bit usb, input bit base, input bit dv);
    rst_ni = 1'b0;
    master_en = 1'b1; usb_mode = usb; base_rate = base; div2 = dv;
    repeat (3) @(negedge clk);
    chk("R11", "outputs in reset", {bclk, lrclk, fstart}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic run_steady(input bit usb, input bit base, input bit dv, input int r,
                            input string r_len);
    int nsamp, bad_lr, bad_bc, bad_fs, f0, f1;
    bit e_lr, e_bc, e_fs;
    do_reset(usb, base, dv);
    nsamp = (2 * r + 8) * (dv ? 2 : 1);
    bad_lr = 0; bad_bc = 0; bad_fs = 0; f0 = -1; f1 = -1;
    for (int t = 0; t < nsamp; t++) begin
      @(posedge clk); @(negedge clk);
      expect_at(t, r, usb, dv, e_lr, e_bc, e_fs);
      if (lrclk !== e_lr) bad_lr++;
      if (bclk !== e_bc) bad_bc++;
      if (fstart !== e_fs) bad_fs++;
      if (fstart === 1'b1) begin
        if (f0 < 0) f0 = t;
        else if (f1 < 0) f1 = t;
      end
    end
    chk(r_len, "master cycles between frame starts", f1 - f0, r * (dv ? 2 : 1));
    chk("R6", "lrclk mismatching cycles", bad_lr, 0);
    chk("R7", "bclk mismatching cycles", bad_bc, 0);
    chk("R8", "frame_start mismatching cycles", bad_fs, 0);
    if (!dv) chk("R11", "first frame start cycle", f0, 0);
  endtask

  // R9: change from 256 to 272 mid-frame; old frame must complete
  task automatic run_change();
    int bad, f0, f1, f2;
    bit e_lr, e_bc, e_fs;
    do_reset(1'b0, 1'b0, 1'b0);
    bad = 0; f0 = -1; f1 = -1; f2 = -1;
    for (int t = 0; t < 256 + 2 * 272 + 4; t++) begin
      @(posedge clk); @(negedge clk);
      if (t < 256) expect_at(t, 256, 1'b0, 1'b0, e_lr, e_bc, e_fs);
      else         expect_at(t - 256, 272, 1'b1, 1'b0, e_lr, e_bc, e_fs);
      if (lrclk !== e_lr || bclk !== e_bc || fstart !== e_fs) bad++;
      if (fstart === 1'b1) begin
        if (f0 < 0) f0 = t;
        else if (f1 < 0) f1 = t;
        else if (f2 < 0) f2 = t;
      end
      if (t == 100) begin usb_mode = 1'b1; base_rate = 1'b1; end
    end
    chk("R9", "length of frame in flight at change", f1 - f0, 256);
    chk("R9", "length of frame after change", f2 - f1, 272);
    chk("R9", "mismatching cycles across change", bad, 0);
  endtask

  // R10: slave operation silences outputs, restart at position 0
  task automatic run_slave();
    int bad;
    do_reset(1'b0, 1'b0, 1'b0);
    for (int t = 0; t < 50; t++) begin
      @(posedge clk); @(negedge clk);
    end
    master_en = 1'b0;
    bad = 0;
    for (int t = 0; t < 20; t++) begin
      @(posedge clk); @(negedge clk);
      if ({bclk, lrclk, fstart} !== 3'b000) bad++;
    end
    chk("R10", "cycles with output active in slave", bad, 0);
    master_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10", "restart lrclk/frame_start/bclk", {lrclk, fstart, bclk}, 3'b110);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R10", "bclk two cycles after restart", bclk, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: cycles actual=%0d expected<%0d", 150000, 150000);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    master_en = 1'b1; usb_mode = 1'b0; base_rate = 1'b0; div2 = 1'b0;
    run_steady(1'b0, 1'b0, 1'b0, 256, "R1");
    run_steady(1'b0, 1'b1, 1'b0, 384, "R2");
    run_steady(1'b1, 1'b0, 1'b0, 250, "R3");
    run_steady(1'b1, 1'b1, 1'b0, 272, "R4");
    run_steady(1'b1, 1'b0, 1'b1, 250, "R5");
    run_steady(1'b0, 1'b1, 1'b1, 384, "R5");
    run_change();
    run_slave();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule